// File: doc/BRIEF.md
# AES-128 Encryption Core with Programmable Automaton Substitution

This block encrypts one 128-bit block under a 128-bit key. It uses an iterative datapath: one round is processed per pass, and the round keys are derived on the fly from the previous round key. The byte substitution is not a fixed table. Each byte goes through a small programmable engine: an 8-cell ring of cells that evolves under an elementary three-neighbour rule for a configured number of steps. The rule byte and the step count are captured together with the plaintext and key, so the same hardware realises a family of substitution functions. Round timing follows the configured step count.

Twenty engines run in lockstep. Sixteen substitute the state bytes and four substitute the rotated last key word. All of them are launched in the same cycle, and the round continues only when every one of them reports completion. The caller pulses `start` with all operands valid. After a fixed number of cycles that depends only on the step count, the block returns the ciphertext with a one-cycle `done` pulse.

Top module: `aes_ca_core`

## Requirements
- R1: During and directly after reset, `done` is 0 and `ciphertext` is all zeros.
- R2: A substitution of byte b under rule byte u with step count N applies N update steps to an 8-bit ring x, starting from x = b. Each step sets every bit at once: x'[i] = u[4*x[(i+7)%8] + 2*x[i] + x[(i+1)%8]]. A step count of 0 behaves as 1.
- R3: The ciphertext is produced in this order: an XOR of the plaintext with the raw key, then 10 rounds (128/32 + 6). Each round substitutes every state byte, applies ShiftRows, applies MixColumns (skipped in round 10), and XORs in the round key.
- R4: Byte k of any 128-bit word occupies bits [127-8k : 120-8k]. State byte 4c+r is row r of column c. ShiftRows rotates row r left by r positions. MixColumns multiplies each column by the circulant matrix with first row 02 03 01 01 over GF(2^8), reduced by x^8+x^4+x^3+x+1.
- R5: Word 0 of a key is bits [127:96]. Each new round key is built from a word t = substitute(rotate-left-one-byte(previous word 3)) XOR {rcon,24'h0}. Then new word 0 = old word 0 ^ t, and each following new word = old word ^ the new word before it. rcon takes the values 01,02,04,08,10,20,40,80,1B,36 for rounds 1 to 10.
- R6: If `start` is sampled at a clock edge, `done` is high in the cycle that lies 10*(N+4)+3 cycles later (243 for N = 20, so the operation spans 244 cycles). N is the step count, with 0 taken as 1.
- R7: `done` is high for exactly one cycle per operation.
- R8: `ciphertext` changes only in the cycle in which `done` is high, and holds its value through a following operation until that operation's `done`.
- R9: A `start` that arrives while an operation is in progress is ignored. The running operation's result and latency are unchanged, and no extra `done` follows.
- R10: `plaintext`, `key`, `rule` and `iters` are sampled only when a `start` is accepted. Changing them later has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an encryption when idle |
| plaintext | input | 128 | Block to encrypt |
| key | input | 128 | Cipher key |
| rule | input | 8 | Three-neighbour update rule for the substitution engines |
| iters | input | ITER_W (6) | Update steps per substitution |
| ciphertext | output | 128 | Registered encrypted block |
| done | output | 1 | One-cycle completion pulse |

## Verification
The latency property assumes that `start` is sampled with a well-defined `iters`. It also assumes that reset has cleared any operation in progress, so every `done` can be matched to the most recently accepted `start`. The lockstep property assumes that all twenty engines see one shared launch and one captured step count. The bench drives every input only at falling edges and releases reset before the first `start`. It uses step counts from 0 to 20, and it exercises the ignored `start` with operands that differ from those of the running operation.

// File: rtl/aes_ca_pkg.sv
package aes_ca_pkg;
  localparam int BLK_W = 128;
  localparam int KEY_W = 128;
  localparam int NB    = BLK_W / 8;
  localparam int NKW   = KEY_W / 32;
  localparam int NR    = KEY_W / 32 + 6;
  localparam int RULE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_LAUNCH, PH_WAIT, PH_MIX, PH_ADDKEY, PH_EMIT
  } phase_t;

  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [BLK_W-1:0] rot_rows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_W-1-8*(4*c+r) -: 8] = s[BLK_W-1-8*(4*((c+r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] mix_all(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[BLK_W-1-32*c -: 8];
      a1 = s[BLK_W-9-32*c -: 8];
      a2 = s[BLK_W-17-32*c -: 8];
      a3 = s[BLK_W-25-32*c -: 8];
      o[BLK_W-1-32*c  -: 8] = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
      o[BLK_W-9-32*c  -: 8] = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
      o[BLK_W-17-32*c -: 8] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
      o[BLK_W-25-32*c -: 8] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
    end
    return o;
  endfunction
endpackage

// File: rtl/ca_subst_unit.sv
module ca_subst_unit #(
  parameter int CELLS  = 8,
  parameter int ITER_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [CELLS-1:0]  din,
  input  logic [7:0]        rule,
  input  logic [ITER_W-1:0] steps,
  output logic [CELLS-1:0]  dout,
  output logic              fin
);
  logic [CELLS-1:0]  ring_q, ring_nx;
  logic [ITER_W-1:0] cnt_q;
  logic              run_q;
  logic [ITER_W:0]   cnt_inc;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam int LEFT  = (i + CELLS - 1) % CELLS;
    localparam int RIGHT = (i + 1) % CELLS;
    assign ring_nx[i] = rule[{ring_q[LEFT], ring_q[i], ring_q[RIGHT]}];
  end

  assign cnt_inc = {1'b0, cnt_q} + {{ITER_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fin    <= 1'b0;
    end else if (launch) begin
      ring_q <= din;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      fin    <= 1'b0;
    end else if (run_q) begin
      ring_q <= ring_nx;
      cnt_q  <= cnt_inc[ITER_W-1:0];
      if (cnt_inc >= {1'b0, steps}) begin
        run_q <= 1'b0;
        fin   <= 1'b1;
      end
    end
  end

  assign dout = ring_q;
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step #(
  parameter int KW = 128
) (
  input  logic [KW-1:0] cur_key,
  input  logic [31:0]   sub_word,
  input  logic [7:0]    rcon,
  output logic [KW-1:0] next_key
);
  localparam int NW = KW / 32;
  logic [31:0] mixw;
  logic [31:0] nw [NW];

  assign mixw = sub_word ^ {rcon, 24'h0};

  for (genvar j = 0; j < NW; j++) begin : g_word
    if (j == 0) begin : g_first
      assign nw[j] = cur_key[KW-1 -: 32] ^ mixw;
    end else begin : g_rest
      assign nw[j] = cur_key[KW-1-32*j -: 32] ^ nw[j-1];
    end
    assign next_key[KW-1-32*j -: 32] = nw[j];
  end
endmodule

// File: rtl/aes_ca_core.sv
module aes_ca_core
  import aes_ca_pkg::*;
#(
  parameter int ITER_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [127:0]      plaintext,
  input  logic [127:0]      key,
  input  logic [7:0]        rule,
  input  logic [ITER_W-1:0] iters,
  output logic [127:0]      ciphertext,
  output logic              done
);
  localparam int NU    = NB + 4;
  localparam int RND_W = $clog2(NR + 1);

  phase_t             phase_q;
  logic [BLK_W-1:0]   state_q;
  logic [KEY_W-1:0]   rkey_q, rkey_nx;
  logic [7:0]         rule_q, rcon_q;
  logic [ITER_W-1:0]  iters_q;
  logic [RND_W-1:0]   round_q;
  logic [31:0]        sword_q, rot_w, sword_w;
  logic [BLK_W-1:0]   sub_bytes;
  logic [NU-1:0]      sub_done;
  logic               launch, busy;

  assign launch = (phase_q == PH_LAUNCH);
  assign busy   = (phase_q != PH_IDLE);
  assign rot_w  = {rkey_q[23:0], rkey_q[31:24]};

  for (genvar b = 0; b < NB; b++) begin : g_state_sub
    ca_subst_unit #(.CELLS(8), .ITER_W(ITER_W)) i_unit (
      .clk(clk), .rst(rst), .launch(launch),
      .din(state_q[BLK_W-1-8*b -: 8]), .rule(rule_q), .steps(iters_q),
      .dout(sub_bytes[BLK_W-1-8*b -: 8]), .fin(sub_done[b])
    );
  end

  for (genvar j = 0; j < 4; j++) begin : g_key_sub
    ca_subst_unit #(.CELLS(8), .ITER_W(ITER_W)) i_unit (
      .clk(clk), .rst(rst), .launch(launch),
      .din(rot_w[31-8*j -: 8]), .rule(rule_q), .steps(iters_q),
      .dout(sword_w[31-8*j -: 8]), .fin(sub_done[NB+j])
    );
  end

  aes_key_step #(.KW(KEY_W)) i_key_step (
    .cur_key(rkey_q), .sub_word(sword_q), .rcon(rcon_q), .next_key(rkey_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      state_q    <= '0;
      rkey_q     <= '0;
      rule_q     <= '0;
      iters_q    <= '0;
      rcon_q     <= 8'h01;
      round_q    <= RND_W'(1);
      sword_q    <= '0;
      ciphertext <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          state_q <= plaintext;
          rkey_q  <= key;
          rule_q  <= rule;
          iters_q <= iters;
          rcon_q  <= 8'h01;
          round_q <= RND_W'(1);
          phase_q <= PH_LOAD;
        end
        PH_LOAD: begin
          state_q <= state_q ^ rkey_q;
          phase_q <= PH_LAUNCH;
        end
        PH_LAUNCH: phase_q <= PH_WAIT;
        PH_WAIT: if (&sub_done) begin
          state_q <= rot_rows(sub_bytes);
          sword_q <= sword_w;
          phase_q <= PH_MIX;
        end
        PH_MIX: begin
          if (round_q != RND_W'(NR)) state_q <= mix_all(state_q);
          phase_q <= PH_ADDKEY;
        end
        PH_ADDKEY: begin
          state_q <= state_q ^ rkey_nx;
          rkey_q  <= rkey_nx;
          rcon_q  <= gf_dbl(rcon_q);
          if (round_q == RND_W'(NR)) begin
            phase_q <= PH_EMIT;
          end else begin
            round_q <= round_q + RND_W'(1);
            phase_q <= PH_LAUNCH;
          end
        end
        PH_EMIT: begin
          ciphertext <= state_q;
          done       <= 1'b1;
          phase_q    <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aes_ca_core_chk.sv
module aes_ca_core_chk #(
  parameter int ITER_W = 6,
  parameter int NU     = 20,
  parameter int RND_W  = 4,
  parameter int NR     = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic [ITER_W-1:0] iters,
  input logic [NU-1:0]     sub_done,
  input logic [RND_W-1:0]  round_q,
  input logic [127:0]      ciphertext,
  input logic              done
);
  int lat_q;
  int neff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= 0;
      neff_q <= 1;
    end else if (start && !busy) begin
      lat_q  <= 1;
      neff_q <= (iters == '0) ? 1 : int'(iters);
    end else if (lat_q != 0 && lat_q < 100000) begin
      lat_q <= lat_q + 1;
    end
  end

  // R7
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  p_ct_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ciphertext));

  // R6 and R9
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == 10 * (neff_q + 4) + 3));

  // R2
  p_units_lockstep_r2: assert property (@(posedge clk) disable iff (rst)
    (sub_done == '0) || (sub_done == '1));

  // R3
  p_round_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (round_q >= RND_W'(1)) && (round_q <= RND_W'(NR)));
endmodule

bind aes_ca_core aes_ca_core_chk #(
  .ITER_W(ITER_W), .NU(NU), .RND_W(RND_W), .NR(aes_ca_pkg::NR)
) i_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .iters(iters),
  .sub_done(sub_done), .round_q(round_q), .ciphertext(ciphertext), .done(done)
);

// File: tb/test_aes_ca_core.sv
module test_aes_ca_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [127:0] pt_i = '0, key_i = '0;
  logic [7:0]   rule_i = '0;
  logic [5:0]   iters_i = '0;
  logic [127:0] ct_o;
  logic         done_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  aes_ca_core #(.ITER_W(6)) i_aes_ca_core (
    .clk(clk), .rst(rst), .start(start_i), .plaintext(pt_i), .key(key_i),
    .rule(rule_i), .iters(iters_i), .ciphertext(ct_o), .done(done_o)
  );

  localparam int NV = 4;
  localparam logic [127:0] V_PT [NV] = '{
    128'h00112233445566778899aabbccddeeff, 128'h3243f6a8885a308d313198a2e0370734,
    128'h0, 128'hffffffffffffffffffffffffffffffff};
  localparam logic [127:0] V_KEY [NV] = '{
    128'h000102030405060708090a0b0c0d0e0f, 128'h2b7e151628aed2a6abf7158809cf4f3c,
    128'h0, 128'ha5a5a5a55a5a5a5a0f0f0f0ff0f0f0f0};
  localparam logic [7:0] V_RULE [NV] = '{8'h1e, 8'h96, 8'h2d, 8'h69};
  localparam logic [5:0] V_N [NV] = '{6'd8, 6'd20, 6'd3, 6'd1};

  function automatic logic [7:0] ref_sub(input logic [7:0] b, input logic [7:0] u, input int n);
    logic [7:0] x, y;
    int m;
    m = (n == 0) ? 1 : n;
    x = b;
    for (int t = 0; t < m; t++) begin
      for (int i = 0; i < 8; i++) y[i] = u[{x[(i+7)%8], x[i], x[(i+1)%8]}];
      x = y;
    end
    return x;
  endfunction

  function automatic logic [7:0] dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k0,
                                           input logic [7:0] u, input int n);
    logic [7:0] s [16];
    logic [7:0] k [16];
    logic [7:0] tm [16];
    logic [7:0] t [4];
    logic [7:0] rc;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      k[i] = k0[127-8*i -: 8];
      s[i] = p[127-8*i -: 8] ^ k[i];
    end
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = ref_sub(s[i], u, n);
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) tm[4*c+w] = s[4*((c+w)%4)+w];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          s[4*c]   = dbl(tm[4*c]) ^ dbl(tm[4*c+1]) ^ tm[4*c+1] ^ tm[4*c+2] ^ tm[4*c+3];
          s[4*c+1] = tm[4*c] ^ dbl(tm[4*c+1]) ^ dbl(tm[4*c+2]) ^ tm[4*c+2] ^ tm[4*c+3];
          s[4*c+2] = tm[4*c] ^ tm[4*c+1] ^ dbl(tm[4*c+2]) ^ dbl(tm[4*c+3]) ^ tm[4*c+3];
          s[4*c+3] = dbl(tm[4*c]) ^ tm[4*c] ^ tm[4*c+1] ^ tm[4*c+2] ^ dbl(tm[4*c+3]);
        end else begin
          for (int w = 0; w < 4; w++) s[4*c+w] = tm[4*c+w];
        end
      end
      t[0] = ref_sub(k[13], u, n) ^ rc;
      t[1] = ref_sub(k[14], u, n);
      t[2] = ref_sub(k[15], u, n);
      t[3] = ref_sub(k[12], u, n);
      for (int i = 0; i < 4; i++) k[i] = k[i] ^ t[i];
      for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
      rc = dbl(rc);
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [127:0] p, input logic [127:0] k, input logic [7:0] u,
                        input logic [5:0] n);
    pt_i = p; key_i = k; rule_i = u; iters_i = n; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(inout int lat);
    while (!done_o && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int lat;
    logic [127:0] exp_ct, prev_ct;
    bit stable;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && ct_o == '0, "R1 in reset", {127'b0, done_o} ^ ct_o, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0 && ct_o == '0, "R1 after reset", ct_o, '0);

    // vector table: R2 R3 R4 R5 result, R6 latency, R7 pulse width
    for (int v = 0; v < NV; v++) begin
      exp_ct = ref_enc(V_PT[v], V_KEY[v], V_RULE[v], int'(V_N[v]));
      launch(V_PT[v], V_KEY[v], V_RULE[v], V_N[v]);
      lat = 1;
      wait_done(lat);
      chk(ct_o == exp_ct, "R3 R2 R4 R5 ciphertext", ct_o, exp_ct);
      chk(lat == 10 * (int'(V_N[v]) + 4) + 3, "R6 latency", 128'(lat),
          128'(10 * (int'(V_N[v]) + 4) + 3));
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done width", {127'b0, done_o}, '0);
    end

    // R8: result holds while idle
    prev_ct = ct_o;
    stable = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (ct_o != prev_ct || done_o) stable = 1'b0;
    end
    chk(stable, "R8 hold while idle", ct_o, prev_ct);

    // R9 R10: ignored restart with changed operands, R8 hold during run
    exp_ct = ref_enc(V_PT[1], V_KEY[0], V_RULE[2], 5);
    launch(V_PT[1], V_KEY[0], V_RULE[2], 6'd5);
    lat = 1;
    repeat (19) begin
      @(negedge clk);
      lat++;
    end
    chk(ct_o == prev_ct, "R8 hold during run", ct_o, prev_ct);
    pt_i = V_PT[3]; key_i = V_KEY[3]; rule_i = 8'h5a; iters_i = 6'd2; start_i = 1'b1;
    @(negedge clk);
    lat++;
    start_i = 1'b0;
    wait_done(lat);
    chk(ct_o == exp_ct, "R9 R10 result unaffected", ct_o, exp_ct);
    chk(lat == 93, "R9 latency unaffected", 128'(lat), 128'd93);
    stable = 1'b1;
    repeat (120) begin
      @(negedge clk);
      if (done_o) stable = 1'b0;
    end
    chk(stable, "R9 no extra done", {127'b0, ~stable}, '0);

    // R2: step count 0 behaves as 1
    exp_ct = ref_enc(V_PT[0], V_KEY[1], 8'h1e, 1);
    launch(V_PT[0], V_KEY[1], 8'h1e, 6'd0);
    lat = 1;
    wait_done(lat);
    chk(ct_o == exp_ct, "R2 zero steps result", ct_o, exp_ct);
    chk(lat == 53, "R6 zero steps latency", 128'(lat), 128'd53);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done width zero steps", {127'b0, done_o}, '0);

    finish_run();
  end
endmodule